// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an on-chip valid/ready request bus and an external asynchronous byte-wide static RAM. Each accepted request is one read or one write. The block turns it into the matching sequence on the RAM pins. There is no clock on the RAM side, so the controller counts system-clock cycles to meet the RAM's minimum timings. Every interval is a nanosecond parameter. The controller converts it to cycles by rounding up against the clock period parameter.

The RAM is enabled only while both of its chip selects are active: one is active-low and the other is active-high. It has an active-low write strobe, an active-low output enable and a shared 8-bit data path. The controller presents the data path as a separate input, an output and an output-enable, so the pad ring can build the tristate. When no request is being served, every RAM control pin is parked inactive and the RAM stays in standby. When a write follows a read, the controller's data driver waits until the RAM's outputs are certain to have turned off.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, `req_ready` is 1, `mem_sel_n` is 1, `mem_sel` is 0, `mem_wr_n` and `mem_rd_n` are 1, and `mem_dq_oe` is 0.
- R2: A write holds `mem_wr_n` low for exactly NW consecutive cycles. NW = max(c(T_WP_NS), c(T_AS_NS), c(T_DS_NS), c(T_WC_NS) - 1), where c(x) = ceil(x / CLK_NS). During those cycles both selects are active and `mem_dq_oe` is 1.
- R3: A write ends with one cycle in which `mem_wr_n` is high, both selects are still active and `mem_dq_out` is still driven. The byte the RAM latches on that rising strobe equals `req_wdata`.
- R4: A read holds `mem_rd_n` low with both selects active for exactly NR = max(c(T_AA_NS), c(T_OA_NS), c(T_RC_NS)) cycles. `rsp_data` is the value of `mem_dq_in` captured at the clock edge that ends the last of those cycles.
- R5: `rsp_valid` is 1 for exactly one cycle per read, in the first idle cycle after the read. It is never 1 because of a write.
- R6: `mem_dq_oe` never rises earlier than NT = c(T_OZ_NS) cycles after `mem_rd_n` last went high, and it is never 1 while `mem_rd_n` is low.
- R7: `req_ready` drops at the edge that accepts a request. It stays low for NW + 1 cycles for a write whose turnaround is already met, and for NR cycles for a read.
- R8: Outside a request (while `req_ready` is 1) both selects are inactive, so the RAM is in standby.
- R9: `mem_wr_n` and `mem_rd_n` are never low at the same time.
- R10: `mem_addr` does not change in any cycle where the selects were active both in that cycle and in the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_we | input | 1 | 1 = write, 0 = read |
| rsp_data | output | 8 | Byte returned by a read |
| rsp_valid | output | 1 | One-cycle pulse marking `rsp_data` valid |
| mem_addr | output | 18 | RAM address pins |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_in | input | 8 | Data received from the RAM |
| mem_sel_n | output | 1 | Active-low RAM chip select |
| mem_sel | output | 1 | Active-high RAM chip select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low RAM output enable |

## Verification
The main function is driven by a table that mixes write runs, read runs and alternations between the two. The addresses cover all zeros, all ones, alternating bit patterns and an address that was never written. Alternation is what separates a correct turnaround from a driver that turns on too early after a read. The all-ones and alternating addresses catch address bits that are dropped or swapped. The bench RAM model returns a poison byte until the read has lasted NR cycles, so capturing one cycle early gives a visible mismatch. Rewriting a location and reading it back separates a write that really lands from one that leaves the old byte in place.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WWAIT = 3'd1,
    ST_WLOW  = 3'd2,
    ST_WREL  = 3'd3,
    ST_READ  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic wr_n;
    logic rd_n;
    logic dq_oe;
  } pin_bank_t;

  localparam pin_bank_t PINS_PARKED = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1,
                                        rd_n: 1'b1, dq_oe: 1'b0};

  // Smallest whole number of clock cycles covering a nanosecond interval.
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels that belong to each sequencer state.
  function automatic pin_bank_t pins_for(input seq_state_e s);
    pin_bank_t p;
    p = PINS_PARKED;
    case (s)
      ST_WWAIT: begin p.sel_n = 1'b0; p.sel = 1'b1; end
      ST_WLOW:  begin p.sel_n = 1'b0; p.sel = 1'b1; p.wr_n = 1'b0; p.dq_oe = 1'b1; end
      ST_WREL:  begin p.sel_n = 1'b0; p.sel = 1'b1; p.dq_oe = 1'b1; end
      ST_READ:  begin p.sel_n = 1'b0; p.sel = 1'b1; p.rd_n = 1'b0; end
      default:  p = PINS_PARKED;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
  parameter int N_TURN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n_pin,
  output logic turn_ok
);
  localparam int TW = $clog2(N_TURN + 2);
  localparam logic [TW-1:0] SAT = TW'(N_TURN);

  logic [TW-1:0] quiet_q;

  // Counts cycles since the RAM output enable was last released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               quiet_q <= SAT;
    else if (!rd_n_pin)       quiet_q <= '0;
    else if (quiet_q < SAT)   quiet_q <= quiet_q + 1'b1;
  end

  assign turn_ok = (quiet_q >= SAT);
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_d,
  output pin_bank_t  pins_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_PARKED;
    else        pins_q <= pins_for(state_d);
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 45,
  parameter int T_AS_NS = 50,
  parameter int T_DS_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OA_NS = 30,
  parameter int T_RC_NS = 55,
  parameter int T_OZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_we,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n
);
  localparam int N_WLOW = max_int(max_int(ns_to_cycles(T_WP_NS, CLK_NS),
                                          ns_to_cycles(T_AS_NS, CLK_NS)),
                                  max_int(ns_to_cycles(T_DS_NS, CLK_NS),
                                          ns_to_cycles(T_WC_NS, CLK_NS) - 1));
  localparam int N_RD   = max_int(max_int(ns_to_cycles(T_AA_NS, CLK_NS),
                                          ns_to_cycles(T_OA_NS, CLK_NS)),
                                  ns_to_cycles(T_RC_NS, CLK_NS));
  localparam int N_TURN = max_int(ns_to_cycles(T_OZ_NS, CLK_NS), 1);
  localparam int CW     = $clog2(max_int(N_WLOW, N_RD) + 1);

  seq_state_e state_q, state_d;
  pin_bank_t  pins;

  logic              accept;
  logic              rd_capture;
  logic              timer_load;
  logic [CW-1:0]     timer_val;
  logic              timer_done;
  logic              turn_ok;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign rd_capture = (state_q == ST_READ) && timer_done;

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (!req_we) begin
          state_d = ST_READ; timer_load = 1'b1; timer_val = CW'(N_RD - 1);
        end else if (turn_ok) begin
          state_d = ST_WLOW; timer_load = 1'b1; timer_val = CW'(N_WLOW - 1);
        end else begin
          state_d = ST_WWAIT;
        end
      end
      ST_WWAIT: if (turn_ok) begin
        state_d = ST_WLOW; timer_load = 1'b1; timer_val = CW'(N_WLOW - 1);
      end
      ST_WLOW:  if (timer_done) state_d = ST_WREL;
      ST_WREL:  state_d = ST_IDLE;
      ST_READ:  if (timer_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= rd_capture;
      if (rd_capture) rsp_data <= mem_dq_in;
    end
  end

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val), .done(timer_done)
  );

  sram_turn_guard #(.N_TURN(N_TURN)) u_turn (
    .clk(clk), .rst_n(rst_n), .rd_n_pin(pins.rd_n), .turn_ok(turn_ok)
  );

  sram_pin_reg u_pins (
    .clk(clk), .rst_n(rst_n), .state_d(state_d), .pins_q(pins)
  );

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = pins.dq_oe;
  assign mem_sel_n  = pins.sel_n;
  assign mem_sel    = pins.sel;
  assign mem_wr_n   = pins.wr_n;
  assign mem_rd_n   = pins.rd_n;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int N_TURN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rd_capture,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_wr_n,
  input logic              mem_rd_n
);
  logic        chosen;
  logic [15:0] rd_quiet;

  assign chosen = !mem_sel_n && mem_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_quiet <= 16'hFFFF;
    else if (!mem_rd_n)        rd_quiet <= '0;
    else if (rd_quiet != 16'hFFFF) rd_quiet <= rd_quiet + 1'b1;
  end

  assert_parked_when_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe));

  assert_write_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (chosen && mem_dq_oe));

  assert_release_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> chosen);

  assert_capture_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!mem_rd_n && chosen));

  assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_turn_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_rd_n && (rd_quiet >= 16'(N_TURN))));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_wr_n && !mem_rd_n));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chosen && $past(chosen)) |-> $stable(mem_addr));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .N_TURN(N_TURN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rd_capture(rd_capture), .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe),
  .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n)
);

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
  localparam int CLK = 8;

  // Interval in cycles: count up until the cycles cover the nanoseconds.
  function automatic int span(input int ns);
    int n;
    n = 0;
    while (n * CLK < ns) n++;
    return n;
  endfunction
  function automatic int big(input int a, input int b);
    if (a >= b) return a;
    return b;
  endfunction

  localparam int NW = big(big(span(45), span(50)), big(span(25), span(55) - 1));
  localparam int NR = big(big(span(55), span(30)), span(55));
  localparam int NT = span(20);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_we = 1'b0;
  logic [7:0]  rsp_data;
  logic        rsp_valid;
  logic [17:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in = 8'hEE;
  logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n;

  always #(CLK/2) clk = ~clk;

  sram_seq_ctrl #(.CLK_NS(CLK)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // RAM model and pin monitors, all sampled at the falling edge.
  logic [7:0]  ram [logic [17:0]];
  int          rd_age = 0, wr_run = 0, rd_run = 0, last_wr_run = 0, last_rd_run = 0;
  int          rd_quiet = 1000, min_gap = 1000, rsp_count = 0;
  int          park_viol = 0, excl_viol = 0, addr_viol = 0, oe_viol = 0;
  logic        prev_wr_n = 1'b1, prev_oe = 1'b0, prev_chosen = 1'b0;
  logic [17:0] prev_addr = '0;

  function automatic logic [7:0] ram_get(input logic [17:0] a);
    if (ram.exists(a)) return ram[a];
    return 8'h00;
  endfunction

  always @(negedge clk) if (rst_n) begin
    automatic logic chosen = !mem_sel_n && mem_sel;
    if (chosen && !prev_wr_n && mem_wr_n)
      ram[mem_addr] = mem_dq_oe ? mem_dq_out : 8'hEE;
    if (chosen && !mem_rd_n && mem_wr_n) rd_age++; else rd_age = 0;
    mem_dq_in = (rd_age >= NR) ? ram_get(mem_addr) : 8'hEE;
    if (!mem_wr_n) wr_run++; else if (wr_run != 0) begin last_wr_run = wr_run; wr_run = 0; end
    if (!mem_rd_n) rd_run++; else if (rd_run != 0) begin last_rd_run = rd_run; rd_run = 0; end
    if (!mem_rd_n) rd_quiet = 0; else rd_quiet++;
    if (mem_dq_oe && !prev_oe && (rd_quiet - 1) < min_gap) min_gap = rd_quiet - 1;
    if (mem_dq_oe && !mem_rd_n) oe_viol++;
    if (rsp_valid) rsp_count++;
    if (req_ready && (chosen || !mem_wr_n || !mem_rd_n)) park_viol++;
    if (!mem_wr_n && !mem_rd_n) excl_viol++;
    if (chosen && prev_chosen && mem_addr != prev_addr) addr_viol++;
    prev_wr_n = mem_wr_n; prev_oe = mem_dq_oe; prev_chosen = chosen; prev_addr = mem_addr;
  end

  // {we, addr, wdata, expected read byte}
  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 18'h00000, 8'hA5, 8'h00},
    {1'b1, 18'h3FFFF, 8'h5A, 8'h00},
    {1'b1, 18'h15555, 8'hC3, 8'h00},
    {1'b0, 18'h00000, 8'h00, 8'hA5},
    {1'b0, 18'h3FFFF, 8'h00, 8'h5A},
    {1'b1, 18'h2AAAA, 8'h3C, 8'h00},
    {1'b0, 18'h15555, 8'h00, 8'hC3},
    {1'b0, 18'h2AAAA, 8'h00, 8'h3C},
    {1'b1, 18'h00000, 8'hFF, 8'h00},
    {1'b0, 18'h00000, 8'h00, 8'hFF},
    {1'b0, 18'h12345, 8'h00, 8'h00}
  };

  int busy;
  task automatic do_req(input logic we, input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
  endtask

  initial begin
    bit prev_we;
    int rc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready && mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe,
          "R1", "parked pins before reset release", {req_ready, mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe}, 6'b110110);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_sel_n && !mem_sel && !mem_dq_oe, "R1", "parked pins after reset",
          {req_ready, mem_sel_n, mem_sel, mem_dq_oe}, 4'b1100);

    prev_we = 1'b1;
    for (int i = 0; i < NV; i++) begin
      rc = rsp_count;
      do_req(VEC[i][34], VEC[i][33:16], VEC[i][15:8]);
      if (VEC[i][34]) begin
        @(negedge clk);
        check(last_wr_run == NW, "R2", "write strobe cycles", last_wr_run, NW);
        check(ram_get(VEC[i][33:16]) == VEC[i][15:8], "R3", "byte latched", ram_get(VEC[i][33:16]), VEC[i][15:8]);
        if (prev_we) check(busy == NW + 1, "R7", "write busy cycles", busy, NW + 1);
        check(rsp_count == rc, "R5", "no response for write", rsp_count, rc);
      end else begin
        check(rsp_valid == 1'b1, "R5", "response pulse present", rsp_valid, 1);
        check(rsp_data == VEC[i][7:0], "R4", "read byte", rsp_data, VEC[i][7:0]);
        check(busy == NR, "R7", "read busy cycles", busy, NR);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R5", "response pulse one cycle", rsp_valid, 0);
        check(last_rd_run == NR, "R4", "read enable cycles", last_rd_run, NR);
      end
      prev_we = VEC[i][34];
    end

    // Directed: write issued right after a read must wait for the turnaround.
    do_req(1'b0, 18'h00001, 8'h00);
    do_req(1'b1, 18'h00002, 8'h96);
    @(negedge clk);
    check(busy > NW + 1, "R6", "write after read waits", busy, NW + 2);
    check(ram_get(18'h00002) == 8'h96, "R3", "byte latched after turnaround", ram_get(18'h00002), 8'h96);
    check(min_gap >= NT, "R6", "cycles from output-enable release to driver on", min_gap, NT);
    check(oe_viol == 0, "R6", "driver on while RAM output enabled", oe_viol, 0);
    check(park_viol == 0, "R8", "selects active while idle", park_viol, 0);
    check(excl_viol == 0, "R9", "both strobes low", excl_viol, 0);
    check(addr_viol == 0, "R10", "address moved while selected", addr_viol, 0);
    repeat (2) @(negedge clk);
    check(req_ready && mem_sel_n && !mem_sel, "R1", "parked at end", {req_ready, mem_sel_n, mem_sel}, 3'b110);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule